// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Compositor

This block overlays a 64x64 hardware cursor on the outgoing pixel stream, one pixel at a time. The timing side supplies the column and line of each pixel, a valid strobe and the underlying colour. The cursor image lives in an external 1 KB RAM that holds two 1-bit-per-pixel planes. The block reads that RAM through an asynchronous read port. For each pixel inside the cursor window it forms a 2-bit code from the two planes. The selected cursor mode turns that code into one of three results: a substitute colour, an inversion of the underlying pixel, or a pass-through.

The cursor position gives the pixel just past the lower-right corner of the cursor. The window therefore ends one column left of the X value and one line above the Y value. When interlaced scanning is selected, each field shows only the cursor rows of its own parity. A registered output stage adds one cycle of latency and carries a valid flag that stays in step with the pixel stream.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted, and after reset until the first valid pixel, `out_valid` is 0 and `out_kind` is 0 (pass).
- R2: For a pixel at window offset (dx, dy), `rd_addr` is the plane-0 byte address row*8 + (dx/16)*2, and the plane-1 word is at `rd_addr`+512. Each 16-bit word has the byte at the lower address as its high byte. The pixel uses bit 15-(dx mod 16), and its code is plane0_bit + 2*plane1_bit.
- R3: In mode 1, code 0 passes the pixel through, and codes 1, 2 and 3 output colour 1, 2 and 3 respectively, with `out_kind` 1.
- R4: In mode 2, code 0 outputs colour 1 and code 1 outputs colour 2 (`out_kind` 1). Code 2 passes the pixel through. Code 3 outputs the bitwise inverse of all 24 underlying bits, with `out_kind` 2. No other mode ever gives `out_kind` 2.
- R5: In mode 3, code 2 outputs colour 1 and code 3 outputs colour 2. Codes 0 and 1 pass the pixel through.
- R6: In mode 0, every pixel passes through unchanged, whatever the image holds.
- R7: In progressive scan, the window covers columns X-64 to X-1 and lines Y-64 to Y-1. This holds when X-64 or Y-64 would be negative.
- R8: A pass-through result outputs `under_px` unchanged with `out_kind` 0.
- R9: Each valid pixel gives exactly one result, one clock later, with `out_valid` high. A cycle with `pix_valid` low gives `out_valid` low one cycle later.
- R10: With `interlace` high, the window covers lines Y-32 to Y-1 of the field. Field line offset d reads cursor row 2*d + `odd_field`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel strobe for this cycle |
| pix_col | input | 12 | Display column of the pixel |
| pix_line | input | 12 | Display line of the pixel |
| under_px | input | 24 | Underlying pixel colour |
| cur_x | input | 12 | Cursor X position (column past the right edge) |
| cur_y | input | 12 | Cursor Y position (line past the bottom edge) |
| mode | input | 2 | 0 off, 1 three-colour, 2 inverting, 3 two-colour |
| interlace | input | 1 | Interlaced scan select |
| odd_field | input | 1 | Current field parity |
| color1 | input | 24 | Cursor colour 1 |
| color2 | input | 24 | Cursor colour 2 |
| color3 | input | 24 | Cursor colour 3 |
| rd_addr | output | 9 | Plane-0 byte address of the current image word |
| rd_plane0 | input | 16 | Plane-0 word read at rd_addr |
| rd_plane1 | input | 16 | Plane-1 word read at rd_addr+512 |
| out_valid | output | 1 | Result valid |
| out_kind | output | 2 | 0 pass, 1 cursor colour, 2 inverted |
| out_px | output | 24 | Composited pixel |

## Verification
Whole lines are swept across a window at mid-screen in each of the four modes. The image is filled with a varied non-repeating pattern, so every code appears at many bit positions. These sweeps separate the three mappings from one another, expose a wrong bit order or plane swap inside a word, and confirm that the off mode leaves everything untouched. Further sweeps place the window across the screen's top-left corner, and also straddle each window edge by one column and one line, to catch off-by-one errors in the bounds. Interlaced sweeps run in both field parities and show whether the row address uses the doubled index and the parity bit. Idle gaps in the pixel stream check that results appear only for valid pixels.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  typedef enum logic [1:0] {
    K_PASS  = 2'd0,
    K_COLOR = 2'd1,
    K_INV   = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    M_OFF   = 2'd0,
    M_THREE = 2'd1,
    M_XGA   = 2'd2,
    M_XWIN  = 2'd3
  } mode_e;

  localparam int DIM_LOG  = 6;   // cursor is 2**DIM_LOG square
  localparam int WORD_LOG = 4;   // 16-bit image words
endpackage

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_ovl_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CW-1:0]            col,
  input  logic [CW-1:0]            line,
  input  logic [CW-1:0]            cx,
  input  logic [CW-1:0]            cy,
  input  logic                     interlace,
  input  logic                     odd_field,
  output logic                     hit,
  output logic [DIM_LOG+2:0]       rd_addr,
  output logic [WORD_LOG-1:0]      bit_sel
);
  localparam logic [CW:0] FULL = (CW+1)'(1 << DIM_LOG);
  localparam logic [CW:0] HALF = (CW+1)'(1 << (DIM_LOG-1));

  logic [CW:0]        dx, dy;
  logic               hit_x, hit_y;
  logic [DIM_LOG-1:0] row;

  always_comb begin
    dx    = {1'b0, col} + FULL - {1'b0, cx};
    dy    = {1'b0, line} + (interlace ? HALF : FULL) - {1'b0, cy};
    hit_x = (dx[CW:DIM_LOG] == '0);
    if (interlace) begin
      hit_y = (dy[CW:DIM_LOG-1] == '0);
      row   = {dy[DIM_LOG-2:0], odd_field};
    end else begin
      hit_y = (dy[CW:DIM_LOG] == '0);
      row   = dy[DIM_LOG-1:0];
    end
    hit     = hit_x && hit_y;
    rd_addr = {row, dx[DIM_LOG-1:WORD_LOG], 1'b0};
    bit_sel = dx[WORD_LOG-1:0];
  end
endmodule

// File: rtl/cursor_pixmap.sv
module cursor_pixmap
  import cursor_ovl_pkg::*;
#(
  parameter int PW = 24
) (
  input  mode_e          mode,
  input  logic [1:0]     code,
  input  logic [PW-1:0]  color1,
  input  logic [PW-1:0]  color2,
  input  logic [PW-1:0]  color3,
  input  logic [PW-1:0]  under_px,
  output kind_e          kind,
  output logic [PW-1:0]  px
);
  always_comb begin
    kind = K_PASS;
    px   = under_px;
    unique case (mode)
      M_THREE: begin
        unique case (code)
          2'd1:    begin kind = K_COLOR; px = color1; end
          2'd2:    begin kind = K_COLOR; px = color2; end
          2'd3:    begin kind = K_COLOR; px = color3; end
          default: ;
        endcase
      end
      M_XGA: begin
        unique case (code)
          2'd0:    begin kind = K_COLOR; px = color1; end
          2'd1:    begin kind = K_COLOR; px = color2; end
          2'd3:    begin kind = K_INV;   px = ~under_px; end
          default: ;
        endcase
      end
      M_XWIN: begin
        unique case (code)
          2'd2:    begin kind = K_COLOR; px = color1; end
          2'd3:    begin kind = K_COLOR; px = color2; end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int CW = 12,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_col,
  input  logic [CW-1:0] pix_line,
  input  logic [PW-1:0] under_px,
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [1:0]    mode,
  input  logic          interlace,
  input  logic          odd_field,
  input  logic [PW-1:0] color1,
  input  logic [PW-1:0] color2,
  input  logic [PW-1:0] color3,
  output logic [8:0]    rd_addr,
  input  logic [15:0]   rd_plane0,
  input  logic [15:0]   rd_plane1,
  output logic          out_valid,
  output logic [1:0]    out_kind,
  output logic [PW-1:0] out_px
);
  localparam int WBITS = 1 << WORD_LOG;

  logic                hit;
  logic [WORD_LOG-1:0] bit_sel;
  logic [WORD_LOG-1:0] msb_idx;
  logic [1:0]          code;
  mode_e               eff_mode;
  kind_e               kind_d;
  logic [PW-1:0]       px_d;

  cursor_window #(.CW(CW)) u_win (
    .col       (pix_col),
    .line      (pix_line),
    .cx        (cur_x),
    .cy        (cur_y),
    .interlace (interlace),
    .odd_field (odd_field),
    .hit       (hit),
    .rd_addr   (rd_addr),
    .bit_sel   (bit_sel)
  );

  always_comb begin
    msb_idx  = WORD_LOG'(WBITS - 1) - bit_sel;
    code     = {rd_plane1[msb_idx], rd_plane0[msb_idx]};
    eff_mode = hit ? mode_e'(mode) : M_OFF;
  end

  cursor_pixmap #(.PW(PW)) u_map (
    .mode     (eff_mode),
    .code     (code),
    .color1   (color1),
    .color2   (color2),
    .color3   (color3),
    .under_px (under_px),
    .kind     (kind_d),
    .px       (px_d)
  );

  // next-state
  logic          valid_nx;
  logic [1:0]    kind_nx;
  logic [PW-1:0] px_nx;

  always_comb begin
    valid_nx = pix_valid;
    kind_nx  = out_kind;
    px_nx    = out_px;
    if (pix_valid) begin
      kind_nx = kind_d;
      px_nx   = px_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= K_PASS;
      out_px    <= '0;
    end else begin
      out_valid <= valid_nx;
      out_kind  <= kind_nx;
      out_px    <= px_nx;
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_valid,
  input logic [1:0]    mode,
  input logic [PW-1:0] under_px,
  input logic          out_valid,
  input logic [1:0]    out_kind,
  input logic [PW-1:0] out_px
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  // R6
  mode_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mode == 2'd0) |=> (out_kind == 2'd0 && out_px == $past(under_px)));

  // R4
  inv_only_xga_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mode != 2'd2) |=> (out_kind != 2'd2));

  // R4
  inv_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mode == 2'd2) |=> (out_kind != 2'd2 || out_px == ~$past(under_px)));

  // R8
  pass_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (out_kind != 2'd0 || out_px == $past(under_px)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .mode      (mode),
  .under_px  (under_px),
  .out_valid (out_valid),
  .out_kind  (out_kind),
  .out_px    (out_px)
);

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_valid;
  logic [11:0] pix_col, pix_line, cur_x, cur_y;
  logic [23:0] under_px, color1, color2, color3;
  logic [1:0]  mode;
  logic        interlace, odd_field;
  logic [8:0]  rd_addr;
  logic [15:0] rd_plane0, rd_plane1;
  logic        out_valid;
  logic [1:0]  out_kind;
  logic [23:0] out_px;

  always #2 clk = ~clk;

  cursor_overlay u0 (.*);

  logic [7:0] img [1024];
  assign rd_plane0 = {img[{1'b0, rd_addr}], img[{1'b0, rd_addr} + 10'd1]};
  assign rd_plane1 = {img[{1'b1, rd_addr}], img[{1'b1, rd_addr} + 10'd1]};

  typedef struct {
    logic [1:0]  kind;
    logic [23:0] px;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(bit ok, string tag, logic [25:0] act, logic [25:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result from the requirement text (byte/bit formulation)
  task automatic predict(output item_t it);
    int h, dx, dy, row, byte_i, b, code;
    bit p0, p1;
    h  = interlace ? 32 : 64;
    dx = int'(pix_col) - int'(cur_x) + 64;
    dy = int'(pix_line) - int'(cur_y) + h;
    it.kind = 2'd0;
    it.px   = under_px;
    if (mode == 2'd0) begin it.tag = "R6"; return; end
    if (dx < 0 || dx >= 64 || dy < 0 || dy >= h) begin
      it.tag = interlace ? "R10 R8" : "R7 R8";
      return;
    end
    row    = interlace ? 2*dy + int'(odd_field) : dy;
    byte_i = row*8 + dx/8;
    b      = 7 - (dx % 8);
    p0     = img[byte_i][b];
    p1     = img[byte_i + 512][b];
    code   = int'(p0) + 2*int'(p1);
    case (mode)
      2'd1: begin
        it.tag = "R3 R2";
        if (code == 1) begin it.kind = 1; it.px = color1; end
        if (code == 2) begin it.kind = 1; it.px = color2; end
        if (code == 3) begin it.kind = 1; it.px = color3; end
      end
      2'd2: begin
        it.tag = "R4 R2";
        if (code == 0) begin it.kind = 1; it.px = color1; end
        if (code == 1) begin it.kind = 1; it.px = color2; end
        if (code == 3) begin it.kind = 2; it.px = ~under_px; end
      end
      default: begin
        it.tag = "R5 R2";
        if (code == 2) begin it.kind = 1; it.px = color1; end
        if (code == 3) begin it.kind = 1; it.px = color2; end
      end
    endcase
    if (interlace) it.tag = {"R10 ", it.tag};
  endtask

  task automatic drive(int col, int line);
    item_t it;
    @(negedge clk);
    pix_valid = 1'b1;
    pix_col   = 12'(col);
    pix_line  = 12'(line);
    under_px  = {12'(col * 7 + 3), 12'(line * 13 + 5)};
    #0;
    predict(it);
    exp_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b0;
    end
  endtask

  task automatic sweep(int c0, int c1, int l0, int l1);
    for (int l = l0; l <= l1; l++) begin
      for (int c = c0; c <= c1; c++) drive(c, l);
      idle(1);
    end
  endtask

  // monitor: R9 one result per valid pixel, in order
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected result", {out_kind, out_px}, 26'd0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(out_kind == e.kind && out_px == e.px, e.tag,
              {out_kind, out_px}, {e.kind, e.px});
      end
    end
  end

  task automatic finish_run();
    if (exp_q.size() != 0)
      check(1'b0, "R9 missing results", 26'(exp_q.size()), 26'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    done = 1;
    check(1'b0, "watchdog", 26'd0, 26'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) img[i] = 8'((i * 37) ^ (i >> 3) ^ 8'h5A);
    rst_n = 1'b0; pix_valid = 1'b0; pix_col = '0; pix_line = '0; under_px = '0;
    cur_x = 12'd100; cur_y = 12'd80; mode = 2'd1; interlace = 1'b0; odd_field = 1'b0;
    color1 = 24'h112233; color2 = 24'h445566; color3 = 24'h778899;
    repeat (3) @(negedge clk);
    // R1
    check(out_valid == 1'b0 && out_kind == 2'd0, "R1 reset", {out_valid, out_kind}, 26'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_kind == 2'd0, "R1 after reset", {out_valid, out_kind}, 26'd0);

    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      sweep(30, 105, 14, 22);   // top edge and rows
      sweep(34, 37, 76, 81);    // left edge, bottom edge
      sweep(98, 101, 40, 41);   // right edge
    end
    // R7 window across top-left screen corner
    cur_x = 12'd10; cur_y = 12'd5;
    for (int m = 1; m < 4; m++) begin
      mode = 2'(m);
      sweep(0, 12, 0, 6);
    end
    // R10 interlaced, both parities
    cur_x = 12'd200; cur_y = 12'd60; interlace = 1'b1;
    for (int f = 0; f < 2; f++) begin
      odd_field = f[0];
      for (int m = 1; m < 4; m++) begin
        mode = 2'(m);
        sweep(134, 201, 27, 30);
        sweep(134, 201, 58, 60);
      end
    end
    idle(4);
    done = 1;
    finish_run();
  end
endmodule